// File: doc/BRIEF.md
# Register-Access Bridge from AXI4-Lite to a Transceiver Configuration Port

This block lets a processor-side AXI4-Lite master read and update the configuration registers of a serial transceiver. The transceiver exposes them through a dynamic reconfiguration port (DRP). That port is a strobe-based handshake: an enable and a write-enable, a word address, write data, read data, and a ready pulse that comes back when the operation is done. Both sides of the bridge run on one clock. The bridge carries one transaction at a time. It turns an accepted AXI request into a single-cycle DRP strobe, waits for the ready pulse, and then answers on the write-response or read-data channel.

Each AXI channel uses a valid/ready handshake, and the AXI rules for back-pressure apply.
- The bridge raises a ready on an address or data channel only while it is idle and the request is complete. A write needs both the address and the data valid in the same cycle.
- Once a response is valid, it stays valid with a stable payload for as long as the master holds the matching ready low.

A DRP that never answers cannot stall the bus. After a fixed watchdog window the bridge pulses a reset toward the DRP for a few cycles. It then ends the transaction with an error response.

Top module: `axil_drp_bridge`

## Requirements
- R1: After reset, drp_en, drp_we, drp_rst, s_bvalid and s_rvalid are low. With no AXI valid asserted, every AXI ready is low.
- R2: A write is accepted only when s_awvalid and s_wvalid are high together while the bridge is idle. In that cycle s_awready and s_wready are high together. In the following cycle drp_en and drp_we are high for exactly one cycle, drp_addr equals s_awaddr bits [11:2], and drp_di equals s_wdata bits [15:0].
- R3: A read is accepted through s_arready. In the following cycle drp_en is high for exactly one cycle with drp_we low, and drp_addr equals s_araddr bits [11:2].
- R4: A read that completes normally returns s_rdata = {16'h0000, drp_do as sampled with drp_rdy} and s_rresp = 2'b00 (OKAY).
- R5: A write that completes normally returns s_bresp = 2'b00 (OKAY) after drp_rdy.
- R6: From the acceptance of a request until its response handshake, s_awready, s_wready and s_arready stay low.
- R7: When a complete write and a read are both offered to an idle bridge, the write is accepted first and s_arready stays low in that cycle.
- R8: If drp_rdy is not seen in any of the TIMEOUT (500) cycles after the strobe cycle, drp_rst rises TIMEOUT+1 cycles after the strobe cycle and stays high for exactly RST_CYCLES (4) cycles.
- R9: After a timeout the response is 2'b10 (SLVERR), the read data is zero, and no response valid is raised while drp_rst is high.
- R10: s_bvalid and s_rvalid, together with their response and data, stay asserted and unchanged until the matching ready is seen.
- R11: A drp_rdy that arrives in the last cycle of the watchdog window (TIMEOUT cycles after the strobe) completes the transaction with OKAY and no reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awaddr | input | 32 | Write byte address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | 32 | Write data; low 16 bits are used |
| s_wstrb | input | 4 | Write strobes; DRP writes are always full words |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response, OKAY or SLVERR |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Master takes write response |
| s_araddr | input | 32 | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | 32 | Read data, zero-extended |
| s_rresp | output | 2 | Read response, OKAY or SLVERR |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Master takes read data |
| drp_en | output | 1 | One-cycle operation strobe |
| drp_we | output | 1 | Write qualifier for the strobe |
| drp_addr | output | 10 | DRP word address |
| drp_di | output | 16 | DRP write data |
| drp_do | input | 16 | DRP read data |
| drp_rdy | input | 1 | DRP completion pulse |
| drp_rst | output | 1 | Recovery reset pulse toward the DRP |

## Verification
The main race is between the watchdog and the ready pulse. In the last cycle of the window, drp_rdy and the timeout condition can meet. The bench provokes this by setting the DRP model's latency to exactly TIMEOUT and then to TIMEOUT+1. It judges the first case as an OKAY completion with no reset pulse, and the second as a SLVERR with one pulse of exactly RST_CYCLES cycles. A second collision is a write and a read offered to an idle bridge in the same cycle. The bench holds the read valid throughout the write and checks that s_arready stays low until the write response is taken. It then checks that the read returns the value just written.

// File: rtl/drp_bridge_pkg.sv
package drp_bridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_STROBE = 3'd1,
    ST_WAIT   = 3'd2,
    ST_RST    = 3'd3,
    ST_RESP   = 3'd4
  } brg_state_e;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

endpackage

// File: rtl/axil_drp_accept.sv
module axil_drp_accept #(
  parameter int AXI_ADDR_W = 32,
  parameter int AXI_DATA_W = 32,
  parameter int DRP_ADDR_W = 10,
  parameter int DRP_DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  idle_i,
  input  logic [AXI_ADDR_W-1:0] awaddr_i,
  input  logic                  awvalid_i,
  input  logic [AXI_DATA_W-1:0] wdata_i,
  input  logic                  wvalid_i,
  input  logic [AXI_ADDR_W-1:0] araddr_i,
  input  logic                  arvalid_i,
  output logic                  awready_o,
  output logic                  wready_o,
  output logic                  arready_o,
  output logic                  start_o,
  output logic                  req_wr_o,
  output logic [DRP_ADDR_W-1:0] req_addr_o,
  output logic [DRP_DATA_W-1:0] req_data_o
);

  localparam int ADDR_LSB = 2;
  localparam int ADDR_MSB = DRP_ADDR_W + ADDR_LSB - 1;

  logic wr_go;
  logic rd_go;
  logic unused_bits;

  // a write needs address and data together; it outranks a read
  assign wr_go = idle_i & awvalid_i & wvalid_i;
  assign rd_go = idle_i & arvalid_i & ~wr_go;

  assign awready_o = wr_go;
  assign wready_o  = wr_go;
  assign arready_o = rd_go;
  assign start_o   = wr_go | rd_go;

  assign unused_bits = ^{awaddr_i, araddr_i, wdata_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_wr_o   <= 1'b0;
      req_addr_o <= '0;
      req_data_o <= '0;
    end else if (wr_go) begin
      req_wr_o   <= 1'b1;
      req_addr_o <= awaddr_i[ADDR_MSB:ADDR_LSB];
      req_data_o <= wdata_i[DRP_DATA_W-1:0];
    end else if (rd_go) begin
      req_wr_o   <= 1'b0;
      req_addr_o <= araddr_i[ADDR_MSB:ADDR_LSB];
    end
  end

  // R7: the two grants are never given together
  a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !(awready_o && arready_o));

endmodule

// File: rtl/drp_txn_engine.sv
module drp_txn_engine
  import drp_bridge_pkg::*;
#(
  parameter int TIMEOUT    = 500,
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic wr_i,
  input  logic drp_rdy_i,
  input  logic resp_done_i,
  output logic idle_o,
  output logic drp_en_o,
  output logic drp_we_o,
  output logic drp_rst_o,
  output logic hit_o,
  output logic expire_o,
  output logic resp_phase_o
);

  localparam int CNT_W  = $clog2(TIMEOUT + 1);
  localparam int RCNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0]  LAST_WAIT = CNT_W'(TIMEOUT - 1);
  localparam logic [RCNT_W-1:0] LAST_RST  = RCNT_W'(RST_CYCLES - 1);

  brg_state_e        state;
  logic [CNT_W-1:0]  wait_cnt;
  logic [RCNT_W-1:0] rst_cnt;

  assign idle_o       = (state == ST_IDLE);
  assign drp_en_o     = (state == ST_STROBE);
  assign drp_we_o     = (state == ST_STROBE) & wr_i;
  assign drp_rst_o    = (state == ST_RST);
  assign resp_phase_o = (state == ST_RESP);
  assign hit_o        = (state == ST_WAIT) & drp_rdy_i;
  assign expire_o     = (state == ST_WAIT) & ~drp_rdy_i & (wait_cnt == LAST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      wait_cnt <= '0;
      rst_cnt  <= '0;
    end else begin
      case (state)
        ST_IDLE:   if (start_i) state <= ST_STROBE;
        ST_STROBE: begin
          state    <= ST_WAIT;
          wait_cnt <= '0;
        end
        ST_WAIT: begin
          if (drp_rdy_i) begin
            state <= ST_RESP;
          end else if (wait_cnt == LAST_WAIT) begin
            state   <= ST_RST;
            rst_cnt <= '0;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        ST_RST: begin
          if (rst_cnt == LAST_RST) state <= ST_RESP;
          else                     rst_cnt <= rst_cnt + 1'b1;
        end
        ST_RESP:   if (resp_done_i) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  // R2/R3: the strobe lasts one cycle
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    drp_en_o |=> !drp_en_o);

  // R8: the reset pulse only follows an expired window
  a_r8_rst_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drp_rst_o) |-> $past(expire_o));

  // R8: no new strobe during recovery
  a_r8_rst_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    drp_rst_o |-> !drp_en_o);

endmodule

// File: rtl/axil_drp_resp.sv
module axil_drp_resp
  import drp_bridge_pkg::*;
#(
  parameter int AXI_DATA_W = 32,
  parameter int DRP_DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_wr_i,
  input  logic                  hit_i,
  input  logic                  expire_i,
  input  logic [DRP_DATA_W-1:0] drp_do_i,
  input  logic                  resp_phase_i,
  input  logic                  bready_i,
  input  logic                  rready_i,
  output logic                  bvalid_o,
  output logic [1:0]            bresp_o,
  output logic                  rvalid_o,
  output logic [AXI_DATA_W-1:0] rdata_o,
  output logic [1:0]            rresp_o,
  output logic                  done_o
);

  logic [1:0]            resp_q;
  logic [AXI_DATA_W-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_q  <= RESP_OKAY;
      rdata_q <= '0;
    end else if (hit_i) begin
      resp_q  <= RESP_OKAY;
      rdata_q <= req_wr_i ? '0 : AXI_DATA_W'(drp_do_i);
    end else if (expire_i) begin
      resp_q  <= RESP_SLVERR;
      rdata_q <= '0;
    end
  end

  assign bvalid_o = resp_phase_i & req_wr_i;
  assign rvalid_o = resp_phase_i & ~req_wr_i;
  assign bresp_o  = resp_q;
  assign rresp_o  = resp_q;
  assign rdata_o  = rdata_q;
  assign done_o   = (bvalid_o & bready_i) | (rvalid_o & rready_i);

  // R10: write response held until taken
  a_r10_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid_o && !bready_i) |=> (bvalid_o && $stable(bresp_o)));

  // R10: read data held until taken
  a_r10_r_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid_o && !rready_i) |=> (rvalid_o && $stable(rdata_o) && $stable(rresp_o)));

  // R9: an error read carries no data
  a_r9_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid_o && rresp_o == RESP_SLVERR) |-> (rdata_o == '0));

endmodule

// File: rtl/axil_drp_bridge.sv
module axil_drp_bridge #(
  parameter int AXI_ADDR_W = 32,
  parameter int AXI_DATA_W = 32,
  parameter int DRP_ADDR_W = 10,
  parameter int DRP_DATA_W = 16,
  parameter int TIMEOUT    = 500,
  parameter int RST_CYCLES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AXI_ADDR_W-1:0]   s_awaddr,
  input  logic                    s_awvalid,
  output logic                    s_awready,
  input  logic [AXI_DATA_W-1:0]   s_wdata,
  input  logic [AXI_DATA_W/8-1:0] s_wstrb,
  input  logic                    s_wvalid,
  output logic                    s_wready,
  output logic [1:0]              s_bresp,
  output logic                    s_bvalid,
  input  logic                    s_bready,
  input  logic [AXI_ADDR_W-1:0]   s_araddr,
  input  logic                    s_arvalid,
  output logic                    s_arready,
  output logic [AXI_DATA_W-1:0]   s_rdata,
  output logic [1:0]              s_rresp,
  output logic                    s_rvalid,
  input  logic                    s_rready,
  output logic                    drp_en,
  output logic                    drp_we,
  output logic [DRP_ADDR_W-1:0]   drp_addr,
  output logic [DRP_DATA_W-1:0]   drp_di,
  input  logic [DRP_DATA_W-1:0]   drp_do,
  input  logic                    drp_rdy,
  output logic                    drp_rst
);

  logic idle;
  logic start;
  logic req_wr;
  logic hit;
  logic expire;
  logic resp_phase;
  logic resp_done;
  logic unused_strb;

  assign unused_strb = ^s_wstrb;

  axil_drp_accept #(
    .AXI_ADDR_W (AXI_ADDR_W),
    .AXI_DATA_W (AXI_DATA_W),
    .DRP_ADDR_W (DRP_ADDR_W),
    .DRP_DATA_W (DRP_DATA_W)
  ) accept_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .idle_i     (idle),
    .awaddr_i   (s_awaddr),
    .awvalid_i  (s_awvalid),
    .wdata_i    (s_wdata),
    .wvalid_i   (s_wvalid),
    .araddr_i   (s_araddr),
    .arvalid_i  (s_arvalid),
    .awready_o  (s_awready),
    .wready_o   (s_wready),
    .arready_o  (s_arready),
    .start_o    (start),
    .req_wr_o   (req_wr),
    .req_addr_o (drp_addr),
    .req_data_o (drp_di)
  );

  drp_txn_engine #(
    .TIMEOUT    (TIMEOUT),
    .RST_CYCLES (RST_CYCLES)
  ) engine_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .wr_i         (req_wr),
    .drp_rdy_i    (drp_rdy),
    .resp_done_i  (resp_done),
    .idle_o       (idle),
    .drp_en_o     (drp_en),
    .drp_we_o     (drp_we),
    .drp_rst_o    (drp_rst),
    .hit_o        (hit),
    .expire_o     (expire),
    .resp_phase_o (resp_phase)
  );

  axil_drp_resp #(
    .AXI_DATA_W (AXI_DATA_W),
    .DRP_DATA_W (DRP_DATA_W)
  ) resp_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_wr_i     (req_wr),
    .hit_i        (hit),
    .expire_i     (expire),
    .drp_do_i     (drp_do),
    .resp_phase_i (resp_phase),
    .bready_i     (s_bready),
    .rready_i     (s_rready),
    .bvalid_o     (s_bvalid),
    .bresp_o      (s_bresp),
    .rvalid_o     (s_rvalid),
    .rdata_o      (s_rdata),
    .rresp_o      (s_rresp),
    .done_o       (resp_done)
  );

  // R6: no new request is taken while a response is pending
  a_r6_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (s_bvalid || s_rvalid) |-> !(s_awready || s_wready || s_arready));

  // R9: responses wait for the end of the recovery pulse
  a_r9_no_resp_in_rst: assert property (@(posedge clk) disable iff (!rst_n)
    drp_rst |-> !(s_bvalid || s_rvalid));

  // R2: a write strobe follows a write acceptance
  a_r2_we_after_aw: assert property (@(posedge clk) disable iff (!rst_n)
    (drp_en && drp_we) |-> $past(s_awready && s_wready));

endmodule

// File: tb/axil_drp_bridge_tb_top.sv
`timescale 1ns/1ps
module axil_drp_bridge_tb_top;

  localparam int TMO  = 500;
  localparam int RSTC = 4;

  logic        clk;
  logic        rst_n;
  logic [31:0] s_awaddr;
  logic        s_awvalid;
  logic        s_awready;
  logic [31:0] s_wdata;
  logic [3:0]  s_wstrb;
  logic        s_wvalid;
  logic        s_wready;
  logic [1:0]  s_bresp;
  logic        s_bvalid;
  logic        s_bready;
  logic [31:0] s_araddr;
  logic        s_arvalid;
  logic        s_arready;
  logic [31:0] s_rdata;
  logic [1:0]  s_rresp;
  logic        s_rvalid;
  logic        s_rready;
  logic        drp_en;
  logic        drp_we;
  logic [9:0]  drp_addr;
  logic [15:0] drp_di;
  logic [15:0] drp_do;
  logic        drp_rdy;
  logic        drp_rst;

  axil_drp_bridge dut_i (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .drp_en(drp_en), .drp_we(drp_we), .drp_addr(drp_addr), .drp_di(drp_di),
    .drp_do(drp_do), .drp_rdy(drp_rdy), .drp_rst(drp_rst)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // ---------------- DRP imitation ----------------
  logic [15:0] drp_mem [0:1023];
  logic [15:0] ref_mem [0:1023];
  int          lat_cfg = 1;
  int          cd = 0;
  bit          prev_en = 0;
  int          en_double = 0;
  int          strobe_cyc = 0;
  logic [9:0]  cap_addr = '0;
  logic [15:0] cap_di = '0;
  logic        cap_we = 1'b0;

  always @(negedge clk) begin
    drp_rdy = 1'b0;
    if (cd > 0) begin
      cd--;
      if (cd == 0) begin
        drp_rdy = 1'b1;
        drp_do  = drp_mem[cap_addr];
        if (cap_we) drp_mem[cap_addr] = cap_di;
      end
    end
    if (prev_en && drp_en) en_double++;
    prev_en = drp_en;
    if (drp_en) begin
      strobe_cyc = cyc;
      cap_addr   = drp_addr;
      cap_di     = drp_di;
      cap_we     = drp_we;
      cd         = lat_cfg;
    end
  end

  // ---------------- reset-pulse monitor ----------------
  bit prev_rst = 0;
  int rst_rise_cyc = 0;
  int rst_w_cur = 0;
  int rst_w_last = 0;
  int rst_pulses = 0;
  int overlap = 0;

  always @(negedge clk) begin
    if (drp_rst && !prev_rst) begin
      rst_rise_cyc = cyc;
      rst_pulses++;
    end
    if (drp_rst) rst_w_cur++;
    if (!drp_rst && prev_rst) begin
      rst_w_last = rst_w_cur;
      rst_w_cur  = 0;
    end
    if (drp_rst && (s_bvalid || s_rvalid)) overlap++;
    prev_rst = drp_rst;
  end

  int busy_viol = 0;
  int hold_viol = 0;

  function automatic logic [9:0] word_of(input logic [31:0] a);
    return a[11:2];
  endfunction

  task automatic wait_ready_low_until(input bit is_wr);
    do begin
      @(negedge clk); #1;
      if (s_awready || s_wready || s_arready) busy_viol++;
    end while (is_wr ? !s_bvalid : !s_rvalid);
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d, input int lat,
                          input int bdly, output logic [1:0] resp);
    lat_cfg = lat;
    @(negedge clk);
    s_awaddr = a; s_wdata = d; s_wstrb = 4'hF; s_awvalid = 1'b1; s_wvalid = 1'b1;
    #1;
    while (!(s_awready && s_wready)) begin @(negedge clk); #1; end
    @(negedge clk);
    s_awvalid = 1'b0; s_wvalid = 1'b0;
    #1;
    if (s_awready || s_wready || s_arready) busy_viol++;
    if (!s_bvalid) wait_ready_low_until(1'b1);
    resp = s_bresp;
    for (int k = 0; k < bdly; k++) begin
      @(negedge clk); #1;
      if (!s_bvalid || s_bresp != resp) hold_viol++;
    end
    s_bready = 1'b1;
    @(negedge clk);
    s_bready = 1'b0;
    #1;
    if (s_bvalid) hold_viol++;
  endtask

  task automatic do_read(input logic [31:0] a, input int lat, input int rdly,
                         output logic [31:0] data, output logic [1:0] resp);
    lat_cfg = lat;
    @(negedge clk);
    s_araddr = a; s_arvalid = 1'b1;
    #1;
    while (!s_arready) begin @(negedge clk); #1; end
    @(negedge clk);
    s_arvalid = 1'b0;
    #1;
    if (s_awready || s_wready || s_arready) busy_viol++;
    if (!s_rvalid) wait_ready_low_until(1'b0);
    resp = s_rresp;
    data = s_rdata;
    for (int k = 0; k < rdly; k++) begin
      @(negedge clk); #1;
      if (!s_rvalid || s_rresp != resp || s_rdata != data) hold_viol++;
    end
    s_rready = 1'b1;
    @(negedge clk);
    s_rready = 1'b0;
    #1;
    if (s_rvalid) hold_viol++;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [1:0]  rsp;
    logic [31:0] rd;
    int          pulses_before;
    int          strobe_seen;

    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) begin
      drp_mem[i] = 16'(i * 16'h9E37) ^ 16'h5A5A;
      ref_mem[i] = drp_mem[i];
    end
    rst_n = 1'b0;
    s_awaddr = '0; s_awvalid = 1'b0; s_wdata = '0; s_wstrb = '0; s_wvalid = 1'b0;
    s_bready = 1'b0; s_araddr = '0; s_arvalid = 1'b0; s_rready = 1'b0;
    drp_do = '0; drp_rdy = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;

    // R1 reset state
    chk(!drp_en, "R1 drp_en", drp_en, 0);
    chk(!drp_rst, "R1 drp_rst", drp_rst, 0);
    chk(!s_bvalid && !s_rvalid, "R1 resp valids", {s_bvalid, s_rvalid}, 0);
    chk(!s_awready && !s_wready && !s_arready, "R1 readies",
        {s_awready, s_wready, s_arready}, 0);

    // R2 / R5 directed write
    do_write(32'h0000_0104, 32'hABCD_1234, 3, 2, rsp);
    chk(cap_we, "R2 strobe we", cap_we, 1);
    chk(cap_addr == 10'h041, "R2 addr map", cap_addr, 10'h041);
    chk(cap_di == 16'h1234, "R2 data map", cap_di, 16'h1234);
    chk(rsp == 2'b00, "R5 bresp okay", rsp, 0);
    ref_mem[10'h041] = 16'h1234;

    // R3 / R4 directed read with low address bits set
    do_read(32'hF000_0107, 2, 1, rd, rsp);
    chk(!cap_we, "R3 strobe read", cap_we, 0);
    chk(cap_addr == 10'h041, "R3 addr map", cap_addr, 10'h041);
    chk(rd == {16'h0, ref_mem[10'h041]}, "R4 rdata", rd, {16'h0, ref_mem[10'h041]});
    chk(rsp == 2'b00, "R4 rresp okay", rsp, 0);

    // R7 write beats read; R6 read held off until write response taken
    lat_cfg = 2;
    @(negedge clk);
    s_awaddr = 32'h0000_0200; s_wdata = 32'h0000_BEEF; s_wstrb = 4'hF;
    s_awvalid = 1'b1; s_wvalid = 1'b1;
    s_araddr = 32'h0000_0200; s_arvalid = 1'b1;
    #1;
    chk(s_awready && s_wready && !s_arready, "R7 write first",
        {s_awready, s_wready, s_arready}, 3'b110);
    @(negedge clk);
    s_awvalid = 1'b0; s_wvalid = 1'b0;
    strobe_seen = 0;
    do begin
      #1;
      if (s_arready) strobe_seen++;
      if (!s_bvalid) @(negedge clk);
    end while (!s_bvalid);
    repeat (2) begin @(negedge clk); #1; if (s_arready) strobe_seen++; end
    chk(strobe_seen == 0, "R6 read held off", strobe_seen, 0);
    chk(s_bresp == 2'b00, "R7 bresp", s_bresp, 0);
    s_bready = 1'b1;
    @(negedge clk);
    s_bready = 1'b0;
    ref_mem[10'h080] = 16'hBEEF;
    #1;
    while (!s_arready) begin @(negedge clk); #1; end
    @(negedge clk);
    s_arvalid = 1'b0;
    while (!s_rvalid) @(negedge clk);
    #1;
    chk(s_rdata == 32'h0000_BEEF, "R7 read after write", s_rdata, 32'h0000_BEEF);
    s_rready = 1'b1;
    @(negedge clk);
    s_rready = 1'b0;

    // R8 / R9 timeout on a write
    pulses_before = rst_pulses;
    do_write(32'h0000_0010, 32'h0000_7777, 0, 1, rsp);
    chk(rsp == 2'b10, "R9 write slverr", rsp, 2'b10);
    chk(rst_pulses == pulses_before + 1, "R8 one pulse", rst_pulses, pulses_before + 1);
    chk(rst_rise_cyc - strobe_cyc == TMO + 1, "R8 pulse timing",
        rst_rise_cyc - strobe_cyc, TMO + 1);
    chk(rst_w_last == RSTC, "R8 pulse width", rst_w_last, RSTC);
    chk(overlap == 0, "R9 no resp during rst", overlap, 0);

    // R9 timeout on a read
    do_read(32'h0000_0010, 0, 2, rd, rsp);
    chk(rsp == 2'b10, "R9 read slverr", rsp, 2'b10);
    chk(rd == 32'h0, "R9 read zero", rd, 0);
    chk(rst_w_last == RSTC, "R8 pulse width read", rst_w_last, RSTC);

    // R11 ready on the final window cycle
    pulses_before = rst_pulses;
    do_read(32'h0000_0010, TMO, 0, rd, rsp);
    chk(rsp == 2'b00, "R11 last-cycle okay", rsp, 0);
    chk(rd == {16'h0, ref_mem[10'h004]}, "R11 last-cycle data", rd, {16'h0, ref_mem[10'h004]});
    chk(rst_pulses == pulses_before, "R11 no pulse", rst_pulses, pulses_before);
    do_write(32'h0000_0020, 32'h0000_1111, TMO + 1, 0, rsp);
    chk(rsp == 2'b10, "R11 one-late slverr", rsp, 2'b10);
    chk(rst_pulses == pulses_before + 1, "R11 late pulse", rst_pulses, pulses_before + 1);

    // random mix: R2 R3 R4 R5 R10
    for (int n = 0; n < 40; n++) begin
      logic [31:0] a;
      logic [31:0] d;
      int          lat;
      int          dly;
      a   = $urandom;
      d   = $urandom;
      lat = 1 + int'($urandom_range(7));
      dly = int'($urandom_range(3));
      if ($urandom_range(1) == 1) begin
        do_write(a, d, lat, dly, rsp);
        chk(rsp == 2'b00 && cap_we && cap_addr == word_of(a) && cap_di == d[15:0],
            "R2 R5 random write", {rsp, cap_addr, cap_di}, {2'b00, word_of(a), d[15:0]});
        ref_mem[word_of(a)] = d[15:0];
      end else begin
        do_read(a, lat, dly, rd, rsp);
        chk(rsp == 2'b00 && !cap_we && cap_addr == word_of(a), "R3 random read strobe",
            {rsp, cap_addr}, {2'b00, word_of(a)});
        chk(rd == {16'h0, ref_mem[word_of(a)]}, "R4 random rdata", rd,
            {16'h0, ref_mem[word_of(a)]});
      end
    end

    chk(busy_viol == 0, "R6 readies low while busy", busy_viol, 0);
    chk(hold_viol == 0, "R10 response hold", hold_viol, 0);
    chk(en_double == 0, "R2 R3 one-cycle strobe", en_double, 0);
    chk(overlap == 0, "R9 no resp during rst final", overlap, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule